// File: doc/BRIEF.md
# Double-Buffered Synthesizer Control Front End

This block turns host programming traffic into the control word for a frequency synthesizer's divide counters. A 20-bit counter word can arrive in three ways. It can be shifted in one bit at a time on a serial clock, written as three bytes over an 8-bit bus, or taken straight from dedicated pins. The serial and byte paths write a primary register. A promotion strobe copies the primary register into a secondary register. A live select line then chooses which of the two drives the counters, so the next hop frequency can be staged while the current one is in use.

A separate 8-bit enhancement word carries the miscellaneous control bits. It is loaded serially or as one byte, and it sits behind a capture buffer so that the outputs never show a partly shifted value. The control outputs are active only while the active-low enable is asserted.

All strobes are asynchronous to the system clock. Each one passes through a two-flop synchronizer and an edge detector before it acts, so the system clock must run at least four times faster than the serial clock.

Top module: `synth_prog_front`

## Requirements
- R1: `strap_direct` high selects direct mode whatever `strap_serial` is. In direct mode the outputs come straight from the pins: `m_div` = {2'b00, `dir_m`}, `r_div` = {2'b00, `dir_r`}, `a_cnt` = `dir_a`, `pre_en` = `dir_pre_en`. The two banks and `sel_primary` have no effect on them.
- R2: In serial mode (`strap_direct` low, `strap_serial` high), each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of the primary word, moving the older bits toward bit 19. This happens only while both `enh_stb` and `load_stb` are low. The first of 20 bits therefore ends up in bit 19.
- R3: Counter word layout, from bit 19 down to bit 0: r5, r4, m8, m7, prescaler enable, m6..m0, r3..r0, a3..a0. `m_div` = {m8..m0}, `r_div` = {r5..r0}, `a_cnt` = {a3..a0}.
- R4: A rising edge of `load_stb` or of `hop_stb` copies the primary word into the secondary word, in any mode.
- R5: Outside direct mode, `sel_primary` high drives the counter outputs from the primary word and low drives them from the secondary word. The choice takes effect at once.
- R6: In serial mode, while `enh_stb` is high and `load_stb` is low, each rising `ser_clk` edge shifts one bit into the enhancement shift register instead of the counter word. The primary word is left unchanged.
- R7: The enhancement buffer takes the shift register contents only on a falling edge of `enh_stb` in serial mode. The control outputs do not change while bits are being shifted.
- R8: Enhancement word layout, from bit 7 down to bit 0: three unused bits, then `ctl_pwr_dn`, `ctl_cnt_load`, `ctl_msel_out`, `ctl_pre_out` and `ctl_lock_oe`. While `enh_n` is high all five outputs read 0.
- R9: In parallel mode (both straps low), a rising `wr_hi_stb` writes `par_d[3:0]` to word bits 19:16. A rising `wr_mid_stb` writes `par_d` to bits 15:8, and a rising `wr_lo_stb` writes `par_d` to bits 7:0.
- R10: In parallel mode a rising `enh_stb` writes `par_d` into the enhancement buffer. A falling `enh_stb` has no effect in this mode.
- R11: A strobe edge takes effect on the third rising `clk` edge after the strobe changes. Each edge acts exactly once.
- R12: Reset (`rst_n` low, asynchronous) clears both banks, the enhancement state and the synchronizers, so every output reads 0 outside direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_direct | input | 1 | Direct mode strap |
| strap_serial | input | 1 | Serial (high) or parallel (low) strap |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| load_stb | input | 1 | Promote strobe; also blocks shifting while high |
| hop_stb | input | 1 | Hop promote strobe |
| enh_stb | input | 1 | Enhancement shift select / capture / byte strobe |
| wr_hi_stb | input | 1 | Parallel upper nibble strobe |
| wr_mid_stb | input | 1 | Parallel middle byte strobe |
| wr_lo_stb | input | 1 | Parallel low byte strobe |
| par_d | input | 8 | Parallel data bus |
| dir_m | input | 7 | Direct main counter bits m6..m0 |
| dir_r | input | 4 | Direct reference counter bits r3..r0 |
| dir_a | input | 4 | Direct swallow counter bits |
| dir_pre_en | input | 1 | Direct prescaler enable |
| sel_primary | input | 1 | Bank select: 1 primary, 0 secondary |
| enh_n | input | 1 | Active-low enable of the control outputs |
| m_div | output | 9 | Main counter value |
| r_div | output | 6 | Reference counter value |
| a_cnt | output | 4 | Swallow counter value |
| pre_en | output | 1 | Prescaler enable |
| ctl_pwr_dn | output | 1 | Power-down control |
| ctl_cnt_load | output | 1 | Counter load control |
| ctl_msel_out | output | 1 | Modulus select output enable |
| ctl_pre_out | output | 1 | Prescaler output enable |
| ctl_lock_oe | output | 1 | Phase detector output enable |

## Verification
The bench stages a new word while the other bank drives the outputs, then promotes it through each of the two strobes. A design that copied on a level rather than an edge, or that ignored the hop strobe, would show the new word too early or never. Serial shifting is tried with the enhancement strobe high and with the load strobe high. A design that gated the shift wrongly would corrupt the counter word, or would leak half-shifted control bits before the capture edge.

Direct mode is driven with the serial strap set, to confirm that the strap is ignored and the four upper bits are forced low. The byte path is checked for the nibble-only top write and for the latency of exactly three clock edges, where a missing synchronizer stage would move the update one cycle early.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int WORD_W    = 20;
    localparam int BYTE_W    = 8;
    localparam int ENH_ACT_W = 5;
    localparam int M_W       = 9;
    localparam int R_W       = 6;
    localparam int A_W       = 4;
    localparam int NSTB      = 7;

    // strobe slots in the synchronizer vector
    localparam int SI_SCLK = 0;
    localparam int SI_LOAD = 1;
    localparam int SI_HOP  = 2;
    localparam int SI_ENH  = 3;
    localparam int SI_WHI  = 4;
    localparam int SI_WMID = 5;
    localparam int SI_WLO  = 6;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } mode_e;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
        logic           pre;
    } cnt_fields_t;

    function automatic mode_e decode_mode(input logic direct, input logic serial);
        if (direct)      return MODE_DIR;
        else if (serial) return MODE_SER;
        else             return MODE_PAR;
    endfunction

    function automatic cnt_fields_t split_word(input logic [WORD_W-1:0] w);
        cnt_fields_t f;
        f.m   = {w[17], w[16], w[14:8]};
        f.r   = {w[19], w[18], w[7:4]};
        f.a   = w[3:0];
        f.pre = w[15];
        return f;
    endfunction
endpackage

// File: rtl/sp_strobe_sync.sv
module sp_strobe_sync
    import synth_prog_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  sclk_i,
    input  logic  sdat_i,
    input  logic  load_i,
    input  logic  hop_i,
    input  logic  enh_i,
    input  logic  whi_i,
    input  logic  wmid_i,
    input  logic  wlo_i,
    output logic  sh_main_o,
    output logic  sh_enh_o,
    output logic  bit_o,
    output logic  enh_cap_o,
    output logic  enh_par_o,
    output logic  promote_o,
    output logic  wr_hi_o,
    output logic  wr_mid_o,
    output logic  wr_lo_o
);
    typedef struct packed {
        logic [NSTB-1:0] s1;
        logic [NSTB-1:0] s2;
        logic [NSTB-1:0] s3;
        logic            d1;
        logic            d2;
    } sync_t;

    sync_t st_d, st_q;
    logic [NSTB-1:0] raw;
    logic [NSTB-1:0] rise;
    logic            fall_enh, is_ser, is_par;

    always_comb begin
        raw          = '0;
        raw[SI_SCLK] = sclk_i;
        raw[SI_LOAD] = load_i;
        raw[SI_HOP]  = hop_i;
        raw[SI_ENH]  = enh_i;
        raw[SI_WHI]  = whi_i;
        raw[SI_WMID] = wmid_i;
        raw[SI_WLO]  = wlo_i;
    end

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        st_d.d1 = sdat_i;
        st_d.d2 = st_q.d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NSTB; g++) begin : g_edge
        assign rise[g] = st_q.s2[g] & ~st_q.s3[g];
        p_rise_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end

    assign fall_enh  = ~st_q.s2[SI_ENH] & st_q.s3[SI_ENH];
    assign is_ser    = (mode_i == MODE_SER);
    assign is_par    = (mode_i == MODE_PAR);

    assign sh_main_o = is_ser & rise[SI_SCLK] & ~st_q.s2[SI_ENH] & ~st_q.s2[SI_LOAD];
    assign sh_enh_o  = is_ser & rise[SI_SCLK] &  st_q.s2[SI_ENH] & ~st_q.s2[SI_LOAD];
    assign bit_o     = st_q.d2;
    assign enh_cap_o = is_ser & fall_enh;
    assign enh_par_o = is_par & rise[SI_ENH];
    assign promote_o = rise[SI_LOAD] | rise[SI_HOP];
    assign wr_hi_o   = is_par & rise[SI_WHI];
    assign wr_mid_o  = is_par & rise[SI_WMID];
    assign wr_lo_o   = is_par & rise[SI_WLO];
endmodule

// File: rtl/sp_word_bank.sv
module sp_word_bank #(
    parameter int W = 20,
    parameter int B = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         wr_hi_i,
    input  logic         wr_mid_i,
    input  logic         wr_lo_i,
    input  logic [B-1:0] par_i,
    input  logic         promote_i,
    output logic [W-1:0] prim_o,
    output logic [W-1:0] sec_o
);
    localparam int HI_W = W - 2*B;

    typedef struct packed {
        logic [W-1:0] prim;
        logic [W-1:0] sec;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i)   st_d.prim = {st_q.prim[W-2:0], bit_i};
        if (wr_hi_i)   st_d.prim[W-1 -: HI_W] = par_i[HI_W-1:0];
        if (wr_mid_i)  st_d.prim[2*B-1 -: B]  = par_i;
        if (wr_lo_i)   st_d.prim[B-1:0]       = par_i;
        if (promote_i) st_d.sec = st_q.prim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prim_o = st_q.prim;
    assign sec_o  = st_q.sec;

    p_sec_on_promote_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sec) |-> $past(promote_i));
    p_promote_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        promote_i |=> (st_q.sec == $past(st_q.prim)));
    p_prim_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.prim) |-> $past(shift_i || wr_hi_i || wr_mid_i || wr_lo_i));
endmodule

// File: rtl/sp_enh_bank.sv
module sp_enh_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         bit_i,
    input  logic         cap_i,
    input  logic         par_ld_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] hold_o
);
    // only the active low bits are kept; reserved bits fall out of the top
    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] hold;
    } enh_t;

    enh_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i)  st_d.sh   = {st_q.sh[W-2:0], bit_i};
        if (cap_i)    st_d.hold = st_q.sh;
        if (par_ld_i) st_d.hold = par_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    p_hold_on_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.hold) |-> $past(cap_i || par_ld_i));
    p_shift_keeps_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> $stable(st_q.hold));
endmodule

// File: rtl/synth_prog_front.sv
module synth_prog_front
    import synth_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_direct,
    input  logic             strap_serial,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             load_stb,
    input  logic             hop_stb,
    input  logic             enh_stb,
    input  logic             wr_hi_stb,
    input  logic             wr_mid_stb,
    input  logic             wr_lo_stb,
    input  logic [BYTE_W-1:0] par_d,
    input  logic [6:0]       dir_m,
    input  logic [3:0]       dir_r,
    input  logic [3:0]       dir_a,
    input  logic             dir_pre_en,
    input  logic             sel_primary,
    input  logic             enh_n,
    output logic [M_W-1:0]   m_div,
    output logic [R_W-1:0]   r_div,
    output logic [A_W-1:0]   a_cnt,
    output logic             pre_en,
    output logic             ctl_pwr_dn,
    output logic             ctl_cnt_load,
    output logic             ctl_msel_out,
    output logic             ctl_pre_out,
    output logic             ctl_lock_oe
);
    mode_e mode;
    logic sh_main, sh_enh, sbit, enh_cap, enh_par, promote, wr_hi, wr_mid, wr_lo;
    logic [WORD_W-1:0]    prim, sec, dir_word, word;
    logic [ENH_ACT_W-1:0] enh_hold, enh_eff;
    cnt_fields_t          fld;

    assign mode = decode_mode(strap_direct, strap_serial);

    sp_strobe_sync u_sync (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .sclk_i(ser_clk), .sdat_i(ser_dat), .load_i(load_stb), .hop_i(hop_stb),
        .enh_i(enh_stb), .whi_i(wr_hi_stb), .wmid_i(wr_mid_stb), .wlo_i(wr_lo_stb),
        .sh_main_o(sh_main), .sh_enh_o(sh_enh), .bit_o(sbit),
        .enh_cap_o(enh_cap), .enh_par_o(enh_par), .promote_o(promote),
        .wr_hi_o(wr_hi), .wr_mid_o(wr_mid), .wr_lo_o(wr_lo)
    );

    sp_word_bank #(.W(WORD_W), .B(BYTE_W)) u_word (
        .clk(clk), .rst_n(rst_n), .shift_i(sh_main), .bit_i(sbit),
        .wr_hi_i(wr_hi), .wr_mid_i(wr_mid), .wr_lo_i(wr_lo), .par_i(par_d),
        .promote_i(promote), .prim_o(prim), .sec_o(sec)
    );

    sp_enh_bank #(.W(ENH_ACT_W)) u_enh (
        .clk(clk), .rst_n(rst_n), .shift_i(sh_enh), .bit_i(sbit),
        .cap_i(enh_cap), .par_ld_i(enh_par), .par_i(par_d[ENH_ACT_W-1:0]),
        .hold_o(enh_hold)
    );

    // direct word: upper r and m bits tied low
    assign dir_word = {4'b0000, dir_pre_en, dir_m, dir_r, dir_a};

    always_comb begin
        if (mode == MODE_DIR)  word = dir_word;
        else if (sel_primary)  word = prim;
        else                   word = sec;
    end

    assign fld     = split_word(word);
    assign m_div   = fld.m;
    assign r_div   = fld.r;
    assign a_cnt   = fld.a;
    assign pre_en  = fld.pre;

    assign enh_eff      = enh_n ? '0 : enh_hold;
    assign ctl_pwr_dn   = enh_eff[4];
    assign ctl_cnt_load = enh_eff[3];
    assign ctl_msel_out = enh_eff[2];
    assign ctl_pre_out  = enh_eff[1];
    assign ctl_lock_oe  = enh_eff[0];

    p_direct_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strap_direct |-> (m_div[8:7] == 2'b00 && r_div[5:4] == 2'b00));
    p_enh_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> !(ctl_pwr_dn || ctl_cnt_load || ctl_msel_out || ctl_pre_out || ctl_lock_oe));
endmodule

// File: tb/synth_prog_front_tb.sv
module synth_prog_front_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic strap_direct = 0, strap_serial = 1;
    logic ser_clk = 0, ser_dat = 0, load_stb = 0, hop_stb = 0, enh_stb = 0;
    logic wr_hi_stb = 0, wr_mid_stb = 0, wr_lo_stb = 0;
    logic [7:0] par_d = 0;
    logic [6:0] dir_m = 0;
    logic [3:0] dir_r = 0, dir_a = 0;
    logic dir_pre_en = 0, sel_primary = 1, enh_n = 0;
    logic [8:0] m_div;
    logic [5:0] r_div;
    logic [3:0] a_cnt;
    logic pre_en, ctl_pwr_dn, ctl_cnt_load, ctl_msel_out, ctl_pre_out, ctl_lock_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    synth_prog_front u_dut (.*);

    // ---------------- behavioural reference ----------------
    logic [7:0]  h1, h2, h3;   // {sclk,sdat,load,hop,enh,whi,wmid,wlo}
    logic [19:0] m_prim, m_sec;
    logic [7:0]  m_esh, m_ebuf;
    wire [7:0] raw = {ser_clk, ser_dat, load_stb, hop_stb, enh_stb, wr_hi_stb, wr_mid_stb, wr_lo_stb};
    wire is_ser = !strap_direct && strap_serial;
    wire is_par = !strap_direct && !strap_serial;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 <= 0; h2 <= 0; h3 <= 0;
            m_prim <= 0; m_sec <= 0; m_esh <= 0; m_ebuf <= 0;
        end else begin
            h1 <= raw; h2 <= h1; h3 <= h2;
            if (is_ser && h2[7] && !h3[7] && !h2[5]) begin
                if (h2[3]) m_esh  <= {m_esh[6:0], h2[6]};
                else       m_prim <= {m_prim[18:0], h2[6]};
            end
            if (is_par) begin
                if (h2[2] && !h3[2]) m_prim[19:16] <= par_d[3:0];
                if (h2[1] && !h3[1]) m_prim[15:8]  <= par_d;
                if (h2[0] && !h3[0]) m_prim[7:0]   <= par_d;
                if (h2[3] && !h3[3]) m_ebuf        <= par_d;
            end
            if ((h2[5] && !h3[5]) || (h2[4] && !h3[4])) m_sec <= m_prim;
            if (is_ser && !h2[3] && h3[3]) m_ebuf <= m_esh;
        end
    end

    logic [19:0] ew;
    logic [26:0] exp_v, act_v;
    always_comb begin
        ew = strap_direct ? {4'b0, dir_pre_en, dir_m, dir_r, dir_a}
                          : (sel_primary ? m_prim : m_sec);
        exp_v = {ew[17], ew[16], ew[14:8], ew[19], ew[18], ew[7:4], ew[3:0], ew[15],
                 (enh_n ? 5'b0 : m_ebuf[4:0])};
        act_v = {m_div, r_div, a_cnt, pre_en,
                 ctl_pwr_dn, ctl_cnt_load, ctl_msel_out, ctl_pre_out, ctl_lock_oe};
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (act_v !== exp_v) begin
                errors++;
                $display("FAIL R3 model compare actual=%h expected=%h", act_v, exp_v);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ser_bits(input logic [19:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i]; ser_clk = 0; tick(2);
            ser_clk = 1; tick(2);
        end
        ser_clk = 0; tick(4);
    endtask

    task automatic par_write(input int which, input logic [7:0] b);
        par_d = b; tick(1);
        case (which)
            0: wr_lo_stb = 1;
            1: wr_mid_stb = 1;
            2: wr_hi_stb = 1;
            default: enh_stb = 1;
        endcase
        tick(4);
        wr_lo_stb = 0; wr_mid_stb = 0; wr_hi_stb = 0; enh_stb = 0;
        tick(4);
    endtask

    task automatic chk_ctl(input string tag, input logic [4:0] e);
        chk(tag, {ctl_pwr_dn, ctl_cnt_load, ctl_msel_out, ctl_pre_out, ctl_lock_oe}, e);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        // R12 reset state
        chk("R12 m_div in reset", m_div, 0);
        chk_ctl("R12 ctl in reset", 5'b0);
        rst_n = 1; tick(2);
        chk("R12 r_div after reset", r_div, 0);

        // R2/R3 serial counter word, B0 first into bit 19
        ser_bits(20'hA5C3F, 20);
        chk("R2 R3 m_div primary", m_div, 9'h15C);
        chk("R3 r_div primary", r_div, 6'h23);
        chk("R3 a_cnt primary", a_cnt, 4'hF);
        chk("R3 pre_en primary", pre_en, 0);
        sel_primary = 0; tick(1);
        chk("R5 secondary still empty", m_div, 0);
        load_stb = 1; tick(4); load_stb = 0; tick(4);
        chk("R4 load promote", m_div, 9'h15C);

        // R4/R5 hop staging
        ser_bits(20'h0F0F0, 20);
        chk("R5 old word held on secondary", m_div, 9'h15C);
        hop_stb = 1; tick(4); hop_stb = 0; tick(4);
        chk("R4 hop promote m", m_div, 9'h070);
        chk("R4 hop promote r", r_div, 6'h0F);
        chk("R3 hop pre_en", pre_en, 1);
        sel_primary = 1; tick(1);

        // R6/R7/R8 serial enhancement load
        enh_stb = 1; tick(4);
        ser_bits(20'h00016, 8);
        chk_ctl("R7 no change while shifting", 5'b0);
        chk("R6 counter word untouched", m_div, 9'h070);
        enh_stb = 0; tick(4);
        chk_ctl("R8 bit positions after capture", 5'b10110);
        enh_stb = 1; tick(4);
        ser_bits(20'h000E9, 8);
        enh_stb = 0; tick(4);
        chk_ctl("R8 reserved bits dropped", 5'b01001);
        enh_n = 1; tick(1);
        chk_ctl("R8 gated by enh_n", 5'b0);
        enh_n = 0; tick(1);

        // R2 load high blocks shifting
        load_stb = 1; tick(4);
        ser_bits(20'hFFFFF, 20);
        load_stb = 0; tick(4);
        chk("R2 no shift while load high", m_div, 9'h070);

        // R9/R10/R11 parallel mode
        strap_serial = 0; tick(1);
        par_write(2, 8'hFB);
        par_write(1, 8'h81);
        par_write(0, 8'h5A);
        chk("R9 m_div bytes", m_div, 9'h181);
        chk("R9 r_div bytes", r_div, 6'h25);
        chk("R9 a_cnt bytes", a_cnt, 4'hA);
        chk("R9 pre_en bytes", pre_en, 1);
        par_d = 8'h3C; tick(1);
        wr_lo_stb = 1;
        @(posedge clk); @(posedge clk); #1;
        chk("R11 not yet after two edges", a_cnt, 4'hA);
        @(posedge clk); #1;
        chk("R11 updated on third edge", a_cnt, 4'hC);
        @(negedge clk); wr_lo_stb = 0; tick(4);
        par_write(3, 8'h0B);
        chk_ctl("R10 parallel enhancement byte", 5'b01011);
        ser_bits(20'h00000, 4);
        chk("R1 serial clock ignored in parallel", a_cnt, 4'hC);

        // R1 direct mode ignores strap_serial and banks
        strap_direct = 1; strap_serial = 1;
        dir_m = 7'h55; dir_r = 4'hA; dir_a = 4'h3; dir_pre_en = 1; tick(1);
        chk("R1 direct m_div", m_div, 9'h055);
        chk("R1 direct r_div", r_div, 6'h0A);
        chk("R1 direct a_cnt", a_cnt, 4'h3);
        sel_primary = 0; tick(1);
        chk("R1 select ignored in direct", m_div, 9'h055);

        done = 1;
        summary();
        $finish;
    end
endmodule